// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block turns eight external interrupt request lines into eight sticky status flags. Each line is first brought into the clock domain by a synchroniser. It is then watched in one of four sense modes: low level, falling edge, rising edge or both edges. When the chosen condition is seen, the line's flag is set. It stays set until something clears it. A per-line enable masks the flag onto a request output that goes to the interrupt controller.

Software reads all eight flags as one status byte. It can clear a flag only by reading it as 1 and then writing 0 to that bit. Writing 1 to a bit does nothing. Hardware can also clear a flag in two ways:
- An acknowledge from exception handling. In low-level mode this clear only takes effect while the synchronised line is high.
- An acknowledge from a transfer controller, unless that transfer's keep-flag input is set.

A standby input holds every flag at zero.

Top module: `eirq_flag_ctrl`

## Requirements
- R1: After reset, and on every cycle in which `standby` is 1, all flags read as 0 on `bus_rdata`.
- R2: With sense code 2'b00 (low level), a flag sets while the synchronised line is low. The flag stays set after the line returns high.
- R3: With sense code 2'b01 (falling edge), a high-to-low transition sets the flag. A low-to-high transition does not set it.
- R4: With sense code 2'b10 (rising edge), a low-to-high transition sets the flag. A high-to-low transition does not set it.
- R5: With sense code 2'b11 (both edges), either transition sets the flag.
- R6: Writing 1 to a bit leaves its flag unchanged. Writing 0 to a flag that was not read as 1 since the last write also leaves it unchanged.
- R7: Reading a flag as 1 and then writing 0 to that bit clears it. Any write disarms the read tracking, so a second write of 0 needs a fresh read before it can clear.
- R8: An exception acknowledge on a line in any edge mode clears that line's flag.
- R9: An exception acknowledge on a line in low-level mode clears the flag only if the synchronised line is high. While the line is low, the flag stays set.
- R10: A transfer acknowledge clears the flag when `xfer_keep` for that line is 0. It leaves the flag set when `xfer_keep` is 1.
- R11: When a set condition and a clear condition occur in the same cycle, the flag ends up set.
- R12: `req_out[n]` equals flag n ANDed with `req_en[n]`. Bit n of every vector belongs to line n, and the sense code of line n is `sense_cfg[2n+1:2n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Forces all flags and read tracking to zero |
| irq_pin | input | 8 | Asynchronous request lines |
| sense_cfg | input | 16 | Two-bit sense code per line |
| bus_rd | input | 1 | Read strobe for the status byte |
| bus_wr | input | 1 | Write strobe for the status byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current flags |
| exc_ack | input | 8 | Per-line exception handling acknowledge |
| xfer_ack | input | 8 | Per-line transfer controller acknowledge |
| xfer_keep | input | 8 | Per-line keep-flag bit sampled with `xfer_ack` |
| req_en | input | 8 | Per-line request enable |
| req_out | output | 8 | Masked request per line |

## Verification
Each sense mode gets a line of its own. That line is driven through a falling edge and then a rising edge, so the checks show which transitions set the flag and which are ignored. Level mode is also held low and then released. This separates a level that keeps the flag set from an acknowledge that clears it.

Bus sequences compare three cases:
- a write of 0 with no prior read;
- a write of 1;
- a read followed by a write of 0, and a second write of 0 after the tracking has been disarmed.

An edge is timed to land in the same cycle as an acknowledge. This shows whether set or clear takes priority.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic prev;
        logic flag;
        logic armed;
    } chan_st_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int               WIDTH   = 8,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
    import eirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       pin_s,
    input  logic [1:0] sense,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic       wr_bit,
    input  logic       exc_ack,
    input  logic       xfer_ack,
    input  logic       xfer_keep,
    output logic       flag
);

    chan_st_t st_d, st_q;
    logic     set_hit;
    logic     exc_clr;
    logic     xfer_clr;
    logic     sw_clr;
    logic     fall_e;
    logic     rise_e;

    always_comb begin
        fall_e   = st_q.prev & ~pin_s;
        rise_e   = ~st_q.prev & pin_s;
        unique case (sense_e'(sense))
            SENSE_LOW:  set_hit = ~pin_s;
            SENSE_FALL: set_hit = fall_e;
            SENSE_RISE: set_hit = rise_e;
            default:    set_hit = fall_e | rise_e;
        endcase
        exc_clr  = exc_ack & ((sense != SENSE_LOW) | pin_s);
        xfer_clr = xfer_ack & ~xfer_keep;
        sw_clr   = wr_stb & ~wr_bit & st_q.armed;

        st_d.prev  = pin_s;
        st_d.flag  = set_hit | (st_q.flag & ~(exc_clr | xfer_clr | sw_clr));
        st_d.armed = wr_stb ? 1'b0 : (st_q.armed | (rd_stb & st_q.flag));
        if (standby) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b1, flag: 1'b0, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R1: standby forces the flag low on the next cycle
    a_r1_standby_zero: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !flag);

    // R11: a set condition always leaves the flag set
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && !standby) |=> flag);

    // R6: writing 1 with no hardware clear keeps a set flag
    a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_bit && flag && !exc_ack && !xfer_clr && !standby) |=> flag);

    // R7: a write to an unarmed flag cannot clear it
    a_r7_unarmed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !st_q.armed && flag && !exc_ack && !xfer_clr && !standby) |=> flag);

    // R9: in low-level mode an acknowledge while the line is low keeps the flag
    a_r9_low_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ack && sense == SENSE_LOW && !pin_s && !standby) |=> flag);

endmodule

// File: rtl/eirq_flag_ctrl.sv
module eirq_flag_ctrl #(
    parameter int N_LINES     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   standby,
    input  logic [N_LINES-1:0]     irq_pin,
    input  logic [2*N_LINES-1:0]   sense_cfg,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [N_LINES-1:0]     bus_wdata,
    output logic [N_LINES-1:0]     bus_rdata,
    input  logic [N_LINES-1:0]     exc_ack,
    input  logic [N_LINES-1:0]     xfer_ack,
    input  logic [N_LINES-1:0]     xfer_keep,
    input  logic [N_LINES-1:0]     req_en,
    output logic [N_LINES-1:0]     req_out
);

    logic [N_LINES-1:0] pin_s;
    logic [N_LINES-1:0] flags;

    eirq_sync #(
        .WIDTH   (N_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({N_LINES{1'b1}})
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_pin),
        .sync_out (pin_s)
    );

    for (genvar n = 0; n < N_LINES; n++) begin : g_chan
        eirq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .standby   (standby),
            .pin_s     (pin_s[n]),
            .sense     (sense_cfg[2*n +: 2]),
            .rd_stb    (bus_rd),
            .wr_stb    (bus_wr),
            .wr_bit    (bus_wdata[n]),
            .exc_ack   (exc_ack[n]),
            .xfer_ack  (xfer_ack[n]),
            .xfer_keep (xfer_keep[n]),
            .flag      (flags[n])
        );
    end

    assign bus_rdata = flags;
    assign req_out   = flags & req_en;

    // R12: a disabled line never requests
    a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out & ~req_en) == '0);

endmodule

// File: tb/eirq_flag_ctrl_tb_top.sv
module eirq_flag_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic [7:0]  irq_pin = 8'hFF;
    logic [15:0] sense_cfg = 16'h5555;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'hFF;
    logic [7:0]  bus_rdata;
    logic [7:0]  exc_ack = '0;
    logic [7:0]  xfer_ack = '0;
    logic [7:0]  xfer_keep = '0;
    logic [7:0]  req_en = '0;
    logic [7:0]  req_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eirq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby), .irq_pin(irq_pin),
        .sense_cfg(sense_cfg), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exc_ack(exc_ack),
        .xfer_ack(xfer_ack), .xfer_keep(xfer_keep), .req_en(req_en),
        .req_out(req_out)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_mode(int ch, logic [1:0] m);
        sense_cfg[2*ch +: 2] = m;
    endtask

    task automatic drive(int ch, logic v);
        irq_pin[ch] = v;
        tick(4);
    endtask

    task automatic pulse_exc(int ch);
        exc_ack[ch] = 1'b1; tick(1); exc_ack[ch] = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset flags", bus_rdata == 8'h00, 1'b1);
        chk("R1 reset req", req_out == 8'h00, 1'b1);
    endtask

    task automatic t_low;
        set_mode(0, 2'b00);
        tick(2);
        chk("R2 low idle high", bus_rdata[0], 1'b0);
        drive(0, 1'b0);
        chk("R2 low sets", bus_rdata[0], 1'b1);
        pulse_exc(0);
        chk("R9 ack while low keeps", bus_rdata[0], 1'b1);
        drive(0, 1'b1);
        chk("R2 sticky after release", bus_rdata[0], 1'b1);
        pulse_exc(0);
        chk("R9 ack while high clears", bus_rdata[0], 1'b0);
    endtask

    task automatic t_fall;
        set_mode(1, 2'b01);
        drive(1, 1'b0);
        chk("R3 falling sets", bus_rdata[1], 1'b1);
        pulse_exc(1);
        chk("R8 edge ack clears", bus_rdata[1], 1'b0);
        drive(1, 1'b1);
        chk("R3 rising ignored", bus_rdata[1], 1'b0);
    endtask

    task automatic t_rise;
        set_mode(2, 2'b10);
        drive(2, 1'b0);
        chk("R4 falling ignored", bus_rdata[2], 1'b0);
        drive(2, 1'b1);
        chk("R4 rising sets", bus_rdata[2], 1'b1);
        pulse_exc(2);
        chk("R8 rise ack clears", bus_rdata[2], 1'b0);
    endtask

    task automatic t_both;
        set_mode(3, 2'b11);
        drive(3, 1'b0);
        chk("R5 fall sets", bus_rdata[3], 1'b1);
        pulse_exc(3);
        chk("R8 both ack clears", bus_rdata[3], 1'b0);
        drive(3, 1'b1);
        chk("R5 rise sets", bus_rdata[3], 1'b1);
        pulse_exc(3);
    endtask

    task automatic t_sw;
        set_mode(4, 2'b01);
        drive(4, 1'b0);
        irq_pin[4] = 1'b1; tick(3);
        chk("R3 set before sw", bus_rdata[4], 1'b1);
        bus_wr = 1'b1; bus_wdata = 8'h00; tick(1); bus_wr = 1'b0;
        chk("R6 write0 unread keeps", bus_rdata[4], 1'b1);
        bus_rd = 1'b1; tick(1); bus_rd = 1'b0;
        bus_wr = 1'b1; bus_wdata = 8'hFF; tick(1); bus_wr = 1'b0;
        chk("R6 write1 keeps", bus_rdata[4], 1'b1);
        bus_wr = 1'b1; bus_wdata = 8'h00; tick(1); bus_wr = 1'b0;
        chk("R7 disarmed after write", bus_rdata[4], 1'b1);
        bus_rd = 1'b1; tick(1); bus_rd = 1'b0;
        bus_wr = 1'b1; bus_wdata = 8'hEF; tick(1); bus_wr = 1'b0;
        chk("R7 read then write0 clears", bus_rdata[4], 1'b0);
        bus_wdata = 8'hFF;
    endtask

    task automatic t_xfer;
        set_mode(5, 2'b01);
        drive(5, 1'b0);
        chk("R3 set before xfer", bus_rdata[5], 1'b1);
        xfer_keep[5] = 1'b1; xfer_ack[5] = 1'b1; tick(1); xfer_ack[5] = 1'b0;
        chk("R10 keep holds flag", bus_rdata[5], 1'b1);
        xfer_keep[5] = 1'b0; xfer_ack[5] = 1'b1; tick(1); xfer_ack[5] = 1'b0;
        chk("R10 xfer clears", bus_rdata[5], 1'b0);
        drive(5, 1'b1);
    endtask

    task automatic t_collide;
        set_mode(6, 2'b11);
        drive(6, 1'b0);
        chk("R5 set before collide", bus_rdata[6], 1'b1);
        irq_pin[6] = 1'b1;
        tick(2);
        exc_ack[6] = 1'b1; tick(1); exc_ack[6] = 1'b0;
        chk("R11 set beats ack", bus_rdata[6], 1'b1);
        pulse_exc(6);
        chk("R8 later ack clears", bus_rdata[6], 1'b0);
    endtask

    task automatic t_req;
        set_mode(7, 2'b01);
        drive(7, 1'b0);
        req_en = 8'h00; #1;
        chk("R12 masked low", req_out[7], 1'b0);
        req_en = 8'h80; #1;
        chk("R12 enabled high", req_out[7], 1'b1);
        chk("R12 other lines quiet", req_out[6:0] == 7'h0, 1'b1);
        drive(7, 1'b1);
    endtask

    task automatic t_standby;
        set_mode(0, 2'b00);
        drive(0, 1'b0);
        chk("R2 set before standby", bus_rdata[0], 1'b1);
        standby = 1'b1; tick(2);
        chk("R1 standby clears", bus_rdata == 8'h00, 1'b1);
        standby = 1'b0; drive(0, 1'b1);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_low();
        t_fall();
        t_rise();
        t_both();
        t_sw();
        t_xfer();
        t_collide();
        t_req();
        t_standby();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule